// File: doc/BRIEF.md
# Supply supervisor reset sequencer

This block turns the digitized results of two supply comparators into the internal inactive signal of a card interface controller. One comparator reports that the supply is below its lower threshold. The other reports that the supply is above that threshold plus a hysteresis margin. While the block holds the interface inactive, it blocks every activation command from the system side. When a supply failure is qualified while the interface is active, the block raises a one-cycle request to start the contact deactivation sequence.

A strap input selects how the supply is qualified. In hysteresis mode the supply becomes good only above the upper comparator point, and it fails as soon as it drops under the lower one. In filtered mode only the lower comparator is used: the supply is good while it is above that comparator, and a dip counts as a failure only if it lasts longer than a filter window. In both modes, a supply that becomes good starts one shared hold timer, and the interface stays inactive until that timer expires. All time constants are parameters given in clock cycles. The defaults are a 10 ms hold and a 150 µs filter at 50 MHz.

Top module: `supply_guard`

## Requirements
- R1: While `rstN` is low, and after it is released with the supply not good, `holdInactive` is 1, `deactReq` is 0 and `actGrant` is 0.
- R2: Each comparator input and the mode strap pass through SYNC_STAGES (default 2) flops before use. A change driven just after clock edge n therefore reaches the state register at edge n+3 at the earliest.
- R3: With `modeSelN` = 1 (hysteresis mode), `belowLow` = 1 is a failure, and `aboveHyst` = 1 with `belowLow` = 0 is a good supply. In the band where both inputs are 0, the present active or inactive state is kept.
- R4: After the state machine sees a good supply, `holdInactive` stays 1 for exactly HOLD_CYCLES further cycles and then drops to 0. An input change just after edge n releases the interface at edge n+3+HOLD_CYCLES.
- R5: A qualified failure during the hold countdown returns the block to the failed state without a `deactReq`. The next good supply restarts the hold count from zero.
- R6: With `modeSelN` = 0 (filtered mode), a run of `belowLow` = 1 of at most FILTER_CYCLES cycles is ignored. A run of FILTER_CYCLES+1 cycles or longer is a failure, acted on at edge n+3+FILTER_CYCLES when the run starts just after edge n.
- R7: In filtered mode the supply counts as good whenever `belowLow` is 0. `aboveHyst` is ignored.
- R8: `deactReq` is a single-cycle pulse. It is issued only in the cycle in which `holdInactive` rises from an active state, and never while the interface is already inactive.
- R9: `actGrant` follows `actReq` only while `holdInactive` is 0 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| belowLow | input | 1 | Asynchronous comparator: supply below lower threshold |
| aboveHyst | input | 1 | Asynchronous comparator: supply above threshold plus hysteresis |
| modeSelN | input | 1 | Mode strap: 0 selects filtered mode, 1 (or pulled up) selects hysteresis mode |
| actReq | input | 1 | Activation command from the system controller |
| holdInactive | output | 1 | Interface held inactive |
| deactReq | output | 1 | One-cycle request to deactivate the card contacts |
| actGrant | output | 1 | Activation command passed on while active |

## Verification
The hardest cases to reach from the ports are the ones where a second supply event lands inside the hold countdown. One is a qualified failure that must silently restart the countdown. The other is a sub-window dip in filtered mode that must leave the countdown running. In both cases the only visible effect is the cycle in which `holdInactive` finally falls, or the absence of a pulse. The stimulus therefore drives the first good edge, waits a chosen number of cycles into the countdown, injects a dip whose length is exactly FILTER_CYCLES or FILTER_CYCLES+1, and only then queues the expected release cycle. A release at the stale time, or an extra `deactReq`, shows up as a mismatch at the head of the queue.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [1:0] {
    SG_DOWN = 2'd0,
    SG_WAIT = 2'd1,
    SG_UP   = 2'd2
  } sgState_e;

  typedef struct packed {
    logic clrHold;
    logic incHold;
  } sgStrobe_t;

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import supply_guard_pkg::*;
#(
  parameter int HOLD_CYCLES = 500000,
  parameter int FILTER_CYCLES = 7500,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      belowLowAsync,
  input  logic      aboveHystAsync,
  input  logic      modeSelNAsync,
  input  sgStrobe_t strobe,
  output logic      supplyGood,
  output logic      supplyFail,
  output logic      holdDone
);

  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  logic [2:0] syncOut;
  logic belowS, aboveS, modeSelNS, filtMode, dipLong;

  // R2: all asynchronous inputs go through the synchronizer chain first
  sg_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b101)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({belowLowAsync, aboveHystAsync, modeSelNAsync}),
    .dout(syncOut)
  );

  assign belowS    = syncOut[2];
  assign aboveS    = syncOut[1];
  assign modeSelNS = syncOut[0];
  assign filtMode  = !modeSelNS;

  // Dip-duration filter: counts consecutive below-threshold cycles
  generate
    if (FILTER_CYCLES == 0) begin : g_noFilter
      assign dipLong = 1'b1;
    end else begin : g_filter
      localparam int DIP_W = $clog2(FILTER_CYCLES + 1);
      localparam logic [DIP_W-1:0] DIP_MAX = DIP_W'(FILTER_CYCLES);
      logic [DIP_W-1:0] dipCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dipCnt <= '0;
        end else if (!belowS) begin
          dipCnt <= '0;
        end else if (dipCnt != DIP_MAX) begin
          dipCnt <= dipCnt + 1'b1;
        end
      end

      assign dipLong = (dipCnt == DIP_MAX);

      assert_dip_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
        dipCnt <= DIP_MAX);

      // R6: the counter only advances while the synchronized dip persists
      assert_dip_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
        !belowS |=> dipCnt == '0);
    end
  endgenerate

  // Mode-dependent qualification (R3, R6, R7)
  always_comb begin
    if (filtMode) begin
      supplyFail = belowS && dipLong;
      supplyGood = !belowS;
    end else begin
      supplyFail = belowS;
      supplyGood = aboveS && !belowS;
    end
  end

  // Shared power-good hold timer
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.clrHold) begin
      holdCnt <= '0;
    end else if (strobe.incHold) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == HOLD_LAST);

  assert_hold_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HOLD_LAST);

endmodule

// File: rtl/sg_control.sv
module sg_control
  import supply_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyGood,
  input  logic      supplyFail,
  input  logic      holdDone,
  output sgStrobe_t strobe,
  output logic      holdInactive,
  output logic      deactReq
);

  sgState_e state, stateNext;
  logic deactNext;

  always_comb begin
    stateNext      = state;
    deactNext      = 1'b0;
    strobe.clrHold = 1'b0;
    strobe.incHold = 1'b0;
    unique case (state)
      SG_DOWN: begin
        strobe.clrHold = 1'b1;
        if (supplyGood && !supplyFail) stateNext = SG_WAIT;
      end
      SG_WAIT: begin
        if (supplyFail) begin
          stateNext      = SG_DOWN;
          strobe.clrHold = 1'b1;
        end else if (holdDone) begin
          stateNext      = SG_UP;
          strobe.clrHold = 1'b1;
        end else begin
          strobe.incHold = 1'b1;
        end
      end
      SG_UP: begin
        strobe.clrHold = 1'b1;
        if (supplyFail) begin
          stateNext = SG_DOWN;
          deactNext = 1'b1;
        end
      end
      default: begin
        stateNext      = SG_DOWN;
        strobe.clrHold = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SG_DOWN;
      deactReq <= 1'b0;
    end else begin
      state    <= stateNext;
      deactReq <= deactNext;
    end
  end

  assign holdInactive = (state != SG_UP);

  assert_deact_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    deactReq |=> !deactReq);

  assert_deact_on_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    deactReq |-> (holdInactive && !$past(holdInactive)));

  assert_release_after_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdInactive) |-> $past(holdDone));

  assert_fail_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!holdInactive && supplyFail) |=> (holdInactive && deactReq));

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int HOLD_CYCLES = 500000,
  parameter int FILTER_CYCLES = 7500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic belowLow,
  input  logic aboveHyst,
  input  logic modeSelN,
  input  logic actReq,
  output logic holdInactive,
  output logic deactReq,
  output logic actGrant
);

  sgStrobe_t strobe;
  logic supplyGood, supplyFail, holdDone;

  sg_datapath #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .FILTER_CYCLES(FILTER_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .belowLowAsync (belowLow),
    .aboveHystAsync(aboveHyst),
    .modeSelNAsync (modeSelN),
    .strobe        (strobe),
    .supplyGood    (supplyGood),
    .supplyFail    (supplyFail),
    .holdDone      (holdDone)
  );

  sg_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .supplyGood  (supplyGood),
    .supplyFail  (supplyFail),
    .holdDone    (holdDone),
    .strobe      (strobe),
    .holdInactive(holdInactive),
    .deactReq    (deactReq)
  );

  // R9: commands are blocked while the interface is held inactive
  assign actGrant = actReq && !holdInactive;

endmodule

// File: tb/supply_guard_tb.sv
module supply_guard_tb;

  localparam int H = 40;
  localparam int F = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic belowLow = 1'b1;
  logic aboveHyst = 1'b0;
  logic modeSelN = 1'b1;
  logic actReq = 1'b0;
  logic holdInactive, deactReq, actGrant;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    int    kind;   // 0: interface released, 1: deactivation pulse
    int    at;
    string tag;
  } expEv_t;

  expEv_t expQ[$];

  supply_guard #(
    .HOLD_CYCLES(H),
    .FILTER_CYCLES(F),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .belowLow(belowLow), .aboveHyst(aboveHyst),
    .modeSelN(modeSelN), .actReq(actReq), .holdInactive(holdInactive),
    .deactReq(deactReq), .actGrant(actGrant)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expectEv(input int kind, input int at, input string tag);
    expEv_t e;
    e.kind = kind;
    e.at = at;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic b, input logic a, output int c);
    @(negedge clk);
    belowLow = b;
    aboveHyst = a;
    c = cyc;
  endtask

  // Monitor: detects output events and compares with the queue head
  logic prevHold = 1'b1;
  logic prevDeact = 1'b0;

  task automatic takeEv(input int kind);
    expEv_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "unexpected event", kind, -1);
    end else begin
      e = expQ.pop_front();
      check(e.kind == kind && e.at == cyc, e.tag, cyc, e.at);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevHold && !holdInactive) takeEv(0);
      if (deactReq && !prevDeact) begin
        if (!(holdInactive && !prevHold))
          check(1'b0, "R8 pulse without drop", int'(holdInactive), 1);
        takeEv(1);
      end
      if (holdInactive && !prevHold && !deactReq)
        check(1'b0, "R8 drop without pulse", int'(deactReq), 1);
      if (deactReq && prevDeact)
        check(1'b0, "R8 pulse longer than one cycle", 2, 1);
    end
    prevHold <= holdInactive;
    prevDeact <= deactReq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int c, c1, c2;
    // R1: reset state
    actReq = 1'b1;
    waitCyc(3);
    check(holdInactive == 1'b1, "R1 holdInactive in reset", int'(holdInactive), 1);
    check(deactReq == 1'b0, "R1 deactReq in reset", int'(deactReq), 0);
    check(actGrant == 1'b0, "R1 actGrant in reset", int'(actGrant), 0);
    @(negedge clk);
    rstN = 1'b1;
    waitCyc(10);
    check(holdInactive == 1'b1, "R1 inactive after release", int'(holdInactive), 1);

    // R3: hysteresis band from the failed state does not count as good
    drive(1'b0, 1'b0, c);
    waitCyc(20);
    check(holdInactive == 1'b1, "R3 band keeps inactive", int'(holdInactive), 1);

    // R4/R2: good supply, release after hold time
    drive(1'b0, 1'b1, c);
    expectEv(0, c + 3 + H, "R4 release time");
    waitCyc(H + 10);
    check(actGrant == 1'b1, "R9 grant when active", int'(actGrant), 1);

    // R3: dropping into the band keeps the active state
    drive(1'b0, 1'b0, c);
    waitCyc(10);
    check(holdInactive == 1'b0, "R3 band keeps active", int'(holdInactive), 0);

    // R3/R8: failure from active
    drive(1'b1, 1'b0, c);
    expectEv(1, c + 3, "R3 fail latency");
    waitCyc(10);
    check(actGrant == 1'b0, "R9 grant blocked", int'(actGrant), 0);

    // R5: failure during the countdown restarts it, no pulse
    drive(1'b0, 1'b1, c);
    waitCyc(15);
    drive(1'b1, 1'b0, c1);
    waitCyc(5);
    drive(1'b0, 1'b1, c2);
    expectEv(0, c2 + 3 + H, "R5 restarted hold");
    waitCyc(H + 10);
    check(holdInactive == 1'b0, "R5 active after restart", int'(holdInactive), 0);

    drive(1'b1, 1'b0, c);
    expectEv(1, c + 3, "R8 pulse on fail");
    waitCyc(10);

    // Filtered mode
    @(negedge clk);
    modeSelN = 1'b0;
    waitCyc(10);
    check(holdInactive == 1'b1, "R6 mode switch while down", int'(holdInactive), 1);

    // R7: good = not below, aboveHyst ignored; R6: short dip in countdown ignored
    drive(1'b0, 1'b0, c);
    expectEv(0, c + 3 + H, "R7 filtered release");
    waitCyc(10);
    drive(1'b1, 1'b0, c1);
    waitCyc(F - 1);
    drive(1'b0, 1'b0, c2);
    waitCyc(H);
    check(holdInactive == 1'b0, "R6 dip in countdown ignored", int'(holdInactive), 0);

    // R6: dip of exactly F cycles while active is ignored
    drive(1'b1, 1'b0, c);
    waitCyc(F - 1);
    drive(1'b0, 1'b0, c1);
    waitCyc(20);
    check(holdInactive == 1'b0, "R6 dip of F cycles ignored", int'(holdInactive), 0);

    // R6: dip of F+1 cycles is a failure, then recovery
    drive(1'b1, 1'b0, c);
    expectEv(1, c + 3 + F, "R6 qualified dip");
    waitCyc(F);
    drive(1'b0, 1'b0, c1);
    expectEv(0, c1 + 3 + H, "R6 release after dip");
    waitCyc(H + 10);

    // R5 in filtered mode: long failure, then qualified dip in countdown
    drive(1'b1, 1'b0, c);
    expectEv(1, c + 3 + F, "R8 filtered fail pulse");
    waitCyc(2 * F + 5);
    drive(1'b0, 1'b0, c);
    waitCyc(12);
    drive(1'b1, 1'b0, c1);
    waitCyc(F + 1);
    drive(1'b0, 1'b0, c2);
    expectEv(0, c2 + 3 + H, "R5 filtered restart");
    waitCyc(H + 10);
    check(holdInactive == 1'b0, "R5 filtered active at end", int'(holdInactive), 0);

    check(expQ.size() == 0, "pending expected events", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule